// File: doc/BRIEF.md
# Multi-Mode Serial Frame Receiver

This block receives bytes from one serial line channel and packs them, together with frame boundary markers, into a small receive queue. The channel works in one of two line modes. In the start-bit mode, the data line is oversampled at sixteen times the bit rate. In the clocked mode, an external clock comes with the data and each rising edge delivers one bit. A programmable divisor sets the oversampling tick, so one block covers a wide span of bit rates. The span runs from about a kilobit per second up to the megabit region, limited by the core clock.

On top of the byte stream, one of three acquisition policies decides where frames start and end. The transparent policy stores every byte with no boundary marks. The gap policy opens a frame on the first byte and closes it once the line has stayed quiet for a set number of bit periods. The sync-word policy waits for a programmed pattern and opens a frame on the byte after it. In the clocked mode this pattern also fixes the byte alignment. That frame is then closed by the same quiet-line rule. A four-register write port holds the settings. A consumer reads queue entries through a first-word-fall-through read port.

Top module: `serial_frame_rx`

## Requirements
- R1: In start-bit mode (control bit 0 = 0), an oversampling tick occurs once every divisor+1 clock cycles, and one bit lasts 16 ticks. A character is a low start bit, then 8 data bits with the least significant bit first, then a stop bit. Each bit is sampled near its middle.
- R2: A low level on the line that has returned high by the middle of the start bit is discarded and produces no queue entry.
- R3: A character whose stop bit is sampled low is stored with its error flag (entry bit 8) set. A new start bit is only accepted after the line has been seen high again.
- R4: In clocked mode (control bit 0 = 1), the data input is sampled on each rising edge of the synchronized clock input. Bits are assembled least significant first. In the gap and transparent policies, the first bit after reset or after a quiet gap starts a byte.
- R5: With policy code 0 (control bits 2:1 = 0, transparent), every received byte is stored with both marker bits clear.
- R6: With policy code 1 (gap), the first byte of a frame carries the start marker (entry bit 10). The last byte before a quiet gap carries the end marker (entry bit 9). The quiet time is counted in bit periods. Any line activity or character in progress resets the count. The frame closes when the count reaches the gap register value.
- R7: With policy code 2 (sync word), bytes are discarded until one equals the sync register. The matching byte itself is not stored. The next byte carries the start marker, and a quiet gap ends the frame with the end marker.
- R8: In clocked mode with policy code 2, the pattern is hunted bit by bit. The byte boundary is aligned to the bit that completes the match.
- R9: Each queue entry is 11 bits: start marker in bit 10, end marker in bit 9, error flag in bit 8, data in bits 7:0. The depth is a parameter. The head entry is shown while the valid output is high and is removed by the read strobe.
- R10: A byte that arrives when the queue is full is dropped and sets the overflow flag. The flag stays set until any configuration write clears it.
- R11: Configuration address 0 holds the oversampling divisor. Address 1 holds the control word (bit 0 line mode, bits 2:1 policy); writing it also abandons any open frame. Address 2 holds the sync byte, and address 3 holds the gap length in bit periods.
- R12: After reset the valid output and the overflow flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_async | input | 1 | Serial data line for start-bit mode, idle high |
| sclk_in | input | 1 | External bit clock for clocked mode |
| sdata_in | input | 1 | Data line for clocked mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| rd_en | input | 1 | Removes the head entry of the queue |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 11 | Head entry: markers, error flag, data |
| overflow | output | 1 | Sticky flag for a dropped byte |

## Verification
On every cycle, the assertions check that a full queue keeps its fill level when a byte is dropped. They check that the overflow flag holds until a configuration write and clears right after one. They also check that the head entry stays stable while unread, that transparent entries never carry markers, and that a pattern match only happens while hunting. Only the bench scenarios can show the bit-level behaviour: mid-bit sampling, glitch rejection, framing errors, correct marker placement around quiet gaps, and discarding of bytes ahead of the sync pattern. The same holds for alignment to a pattern that lands in the middle of a clocked bit stream, and for the exact set of entries that survive an overflow. The bench predicts the expected entries from each transmitted stimulus. It compares every entry the receiver delivers.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        ACQ_TRANSPARENT = 2'd0,
        ACQ_GAP         = 2'd1,
        ACQ_SYNCWORD    = 2'd2
    } acq_mode_e;

    typedef struct packed {
        logic       sof;
        logic       eof;
        logic       ferr;
        logic [7:0] data;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

endpackage

// File: rtl/sfr_async_rx.sv
module sfr_async_rx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       os_tick,
    input  logic       rx,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_ferr,
    output logic       busy
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

    typedef struct packed {
        rx_state_e   st;
        logic [CW-1:0] cnt;
        logic [2:0]  idx;
        logic [7:0]  sr;
        logic        vld;
        logic        ferr;
        logic        line_hi;
        logic        s1;
        logic        s2;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.s1   = rx;
        d.s2   = q.s1;
        if (q.st == S_IDLE && q.s2) begin
            d.line_hi = 1'b1;
        end
        if (!en) begin
            d.st = S_IDLE;
        end else if (os_tick) begin
            unique case (q.st)
                S_IDLE: begin
                    if (q.line_hi && !q.s2) begin
                        d.st      = S_START;
                        d.cnt     = '0;
                        d.line_hi = 1'b0;
                    end
                end
                S_START: begin
                    if (q.cnt == MID) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = q.s2 ? S_IDLE : S_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        d.sr  = {q.s2, q.sr[7:1]};
                        d.idx = q.idx + 1'b1;
                        if (q.idx == 3'd7) begin
                            d.st = S_STOP;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (q.cnt == LAST) begin
                        d.vld  = 1'b1;
                        d.ferr = !q.s2;
                        d.st   = S_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.s1   <= 1'b1;
            q.s2   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_valid = q.vld;
    assign byte_data  = q.sr;
    assign byte_ferr  = q.ferr;
    assign busy       = (q.st != S_IDLE);

    // R2: a character is only delivered by the stop state, never straight after a start check
    p_valid_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> $past(q.st) == S_STOP);

endmodule

// File: rtl/sfr_sync_rx.sv
module sfr_sync_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sclk,
    input  logic       sdata,
    input  logic       hunt,
    input  logic       realign,
    input  logic [7:0] sync_word,
    output logic       bit_evt,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       match
);

    typedef struct packed {
        logic       c1;
        logic       c2;
        logic       c3;
        logic       d1;
        logic       d2;
        logic [7:0] sr;
        logic [2:0] cnt;
        logic       vld;
        logic       mt;
    } st_t;

    st_t q, d;
    logic rise;
    logic [7:0] nsr;

    assign rise = q.c2 && !q.c3;
    assign nsr  = {q.d2, q.sr[7:1]};

    always_comb begin
        d     = q;
        d.c1  = sclk;
        d.c2  = q.c1;
        d.c3  = q.c2;
        d.d1  = sdata;
        d.d2  = q.d1;
        d.vld = 1'b0;
        d.mt  = 1'b0;
        if (!en || realign) begin
            d.cnt = '0;
        end else if (rise) begin
            d.sr = nsr;
            if (hunt) begin
                if (nsr == sync_word) begin
                    d.mt  = 1'b1;
                    d.cnt = '0;
                end
            end else if (q.cnt == 3'd7) begin
                d.vld = 1'b1;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bit_evt    = en && rise;
    assign byte_valid = q.vld;
    assign byte_data  = q.sr;
    assign match      = q.mt;

    // R8: a pattern match is only reported while the framer is hunting
    p_match_when_hunting_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(hunt));

endmodule

// File: rtl/sfr_fifo.sv
module sfr_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
    } st_t;

    st_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  count;
    logic         do_push;
    logic         do_pop;

    assign count   = q.wptr - q.rptr;
    assign full    = (count == (AW+1)'(DEPTH));
    assign valid   = (count != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[q.rptr[AW-1:0]];

    always_comb begin
        d = q;
        if (do_push) begin
            d.wptr = q.wptr + 1'b1;
        end
        if (do_pop) begin
            d.rptr = q.rptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[q.wptr[AW-1:0]] <= din;
        end
    end

    // R10: a byte offered to a full queue leaves the fill level unchanged
    p_drop_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> count == $past(count));

    // R9: the fill level never exceeds the depth
    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx #(
    parameter int DEPTH = 8,
    parameter int OSR   = 16,
    parameter int DIV_W = 16,
    parameter int GAP_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_async,
    input  logic        sclk_in,
    input  logic        sdata_in,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic        rd_en,
    output logic        rd_valid,
    output logic [10:0] rd_data,
    output logic        overflow
);
    import sfr_pkg::*;

    localparam int OSR_W = $clog2(OSR);
    localparam logic [OSR_W-1:0] OS_LAST = OSR_W'(OSR - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             clocked;
        logic [1:0]       acq;
        logic [7:0]       sync;
        logic [GAP_W-1:0] gaplen;
        logic [DIV_W-1:0] os_cnt;
        logic [OSR_W-1:0] bt_cnt;
        logic [GAP_W-1:0] gap_cnt;
        logic             gap_armed;
        logic             r1;
        logic             r2;
        logic             r3;
        logic             in_frame;
        logic             fresh;
        logic             pend_v;
        entry_t           pend;
        logic             push;
        entry_t           push_e;
        logic             ovf;
    } st_t;

    st_t q, d;

    logic       os_tick, bit_tick, expire, hunting, act;
    logic       bv, bferr, mt;
    logic [7:0] bdata;
    logic [GAP_W:0] gnext;

    logic       a_vld, a_ferr, a_busy;
    logic [7:0] a_data;
    logic       s_evt, s_vld, s_match;
    logic [7:0] s_data;
    logic       f_full;
    entry_t     f_dout;

    assign os_tick  = (q.os_cnt == q.div);
    assign bit_tick = os_tick && (q.bt_cnt == OS_LAST);
    assign hunting  = (q.acq == ACQ_SYNCWORD) && !q.in_frame;
    assign gnext    = {1'b0, q.gap_cnt} + 1'b1;

    sfr_async_rx #(.OSR(OSR)) i_async (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (!q.clocked),
        .os_tick    (os_tick),
        .rx         (rx_async),
        .byte_valid (a_vld),
        .byte_data  (a_data),
        .byte_ferr  (a_ferr),
        .busy       (a_busy)
    );

    sfr_sync_rx i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (q.clocked),
        .sclk       (sclk_in),
        .sdata      (sdata_in),
        .hunt       (hunting),
        .realign    (expire),
        .sync_word  (q.sync),
        .bit_evt    (s_evt),
        .byte_valid (s_vld),
        .byte_data  (s_data),
        .match      (s_match)
    );

    always_comb begin
        d        = q;
        d.push   = 1'b0;
        d.push_e = '0;
        expire   = 1'b0;
        d.r1     = rx_async;
        d.r2     = q.r1;
        d.r3     = q.r2;

        // oversampling and bit-period tick generation
        if (os_tick) begin
            d.os_cnt = '0;
            d.bt_cnt = q.bt_cnt + 1'b1;
        end else begin
            d.os_cnt = q.os_cnt + 1'b1;
        end

        // byte source selection
        bv    = q.clocked ? s_vld : a_vld;
        bdata = q.clocked ? s_data : a_data;
        bferr = q.clocked ? 1'b0 : a_ferr;
        mt    = q.clocked ? s_match : (a_vld && hunting && (a_data == q.sync));
        act   = q.clocked ? s_evt : ((q.r2 != q.r3) || a_busy);

        // quiet-gap measurement in bit periods
        if (act || bv) begin
            d.gap_cnt   = '0;
            d.gap_armed = 1'b1;
        end else if (bit_tick && q.gap_armed) begin
            if (gnext >= {1'b0, q.gaplen}) begin
                expire      = 1'b1;
                d.gap_armed = 1'b0;
                d.gap_cnt   = '0;
            end else begin
                d.gap_cnt = gnext[GAP_W-1:0];
            end
        end

        // frame delimiting
        if (q.acq == ACQ_GAP || q.acq == ACQ_SYNCWORD) begin
            if (mt) begin
                d.in_frame = 1'b1;
                d.fresh    = 1'b1;
            end else if (bv && (q.in_frame || q.acq == ACQ_GAP)) begin
                if (q.pend_v) begin
                    d.push   = 1'b1;
                    d.push_e = q.pend;
                end
                d.pend.sof  = !q.in_frame || q.fresh;
                d.pend.eof  = 1'b0;
                d.pend.ferr = bferr;
                d.pend.data = bdata;
                d.pend_v    = 1'b1;
                d.in_frame  = 1'b1;
                d.fresh     = 1'b0;
            end else if (expire) begin
                if (q.pend_v) begin
                    d.push       = 1'b1;
                    d.push_e     = q.pend;
                    d.push_e.eof = 1'b1;
                end
                d.pend_v   = 1'b0;
                d.in_frame = 1'b0;
                d.fresh    = 1'b0;
            end
        end else begin
            d.in_frame = 1'b0;
            d.pend_v   = 1'b0;
            d.fresh    = 1'b0;
            if (bv) begin
                d.push        = 1'b1;
                d.push_e.ferr = bferr;
                d.push_e.data = bdata;
            end
        end

        // overflow bookkeeping: set on a dropped byte
        if (q.push && f_full) begin
            d.ovf = 1'b1;
        end

        // configuration writes; any write clears the overflow flag
        if (cfg_we) begin
            d.ovf = 1'b0;
            unique case (cfg_addr)
                2'd0: d.div = cfg_wdata[DIV_W-1:0];
                2'd1: begin
                    d.clocked  = cfg_wdata[0];
                    d.acq      = cfg_wdata[2:1];
                    d.in_frame = 1'b0;
                    d.pend_v   = 1'b0;
                    d.fresh    = 1'b0;
                end
                2'd2: d.sync = cfg_wdata[7:0];
                default: d.gaplen = cfg_wdata[GAP_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.r1     <= 1'b1;
            q.r2     <= 1'b1;
            q.r3     <= 1'b1;
            q.gaplen <= GAP_W'(16);
        end else begin
            q <= d;
        end
    end

    sfr_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q.push),
        .din   (q.push_e),
        .pop   (rd_en),
        .dout  (f_dout),
        .valid (rd_valid),
        .full  (f_full)
    );

    assign rd_data  = f_dout;
    assign overflow = q.ovf;

    // R10: overflow stays set until a configuration write
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !cfg_we) |=> overflow);

    // R10: a configuration write leaves the flag clear
    p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !overflow);

    // R9: an unread head entry stays put
    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data)));

    // R5: transparent entries never carry boundary markers
    p_transparent_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.push && q.acq == ACQ_TRANSPARENT && $past(q.acq) == ACQ_TRANSPARENT)
            |-> (!q.push_e.sof && !q.push_e.eof));

endmodule

// File: tb/test_serial_frame_rx.sv
module test_serial_frame_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_async = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [10:0] rd_data;
    logic        overflow;

    int checks = 0;
    int fails = 0;
    bit drain_en = 1'b1;
    bit done = 1'b0;

    logic [10:0] expq[$];
    string       tagq[$];

    always #2.5 clk = ~clk;

    serial_frame_rx i_serial_frame_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_async  (rx_async),
        .sclk_in   (sclk_in),
        .sdata_in  (sdata_in),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rd_en     (rd_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .overflow  (overflow)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_e(input bit sof, input bit eof, input bit ferr,
                            input logic [7:0] b, input string tag);
        expq.push_back({sof, eof, ferr, b});
        tagq.push_back(tag);
    endtask

    // reference comparison of every delivered entry
    always @(negedge clk) begin
        if (drain_en && rd_valid && !done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected entry", int'(rd_data), 0);
            end else begin
                check(rd_data == expq[0], tagq[0], int'(rd_data), int'(expq[0]));
                void'(expq.pop_front());
                void'(tagq.pop_front());
            end
            rd_en <= 1'b1;
        end else begin
            rd_en <= 1'b0;
        end
    end

    task automatic cfg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_async(input logic [7:0] b, input bit stop_ok);
        rx_async = 1'b0; idle(32);
        for (int i = 0; i < 8; i++) begin
            rx_async = b[i]; idle(32);
        end
        rx_async = stop_ok; idle(32);
        rx_async = 1'b1; idle(4);
    endtask

    task automatic sync_bit(input logic b);
        sdata_in = b; idle(10);
        sclk_in = 1'b1; idle(10);
        sclk_in = 1'b0;
    endtask

    task automatic sync_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) sync_bit(b[i]);
    endtask

    task automatic drained(input string tag);
        idle(20);
        check(expq.size() == 0, tag, expq.size(), 0);
        check(rd_valid == 1'b0, tag, int'(rd_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R12 reset state
        check(rd_valid == 1'b0, "R12 valid after reset", int'(rd_valid), 0);
        check(overflow == 1'b0, "R12 overflow after reset", int'(overflow), 0);

        // R11 configuration: divisor 1, gap 4 bit periods, sync byte A5
        cfg(2'd0, 16'd1);
        cfg(2'd3, 16'd4);
        cfg(2'd2, 16'h00A5);

        // R1 R6 start-bit mode, gap policy
        cfg(2'd1, 16'h0002);
        expect_e(1, 0, 0, 8'h3C, "R6 frame first byte");
        expect_e(0, 0, 0, 8'hFF, "R1 middle byte");
        expect_e(0, 1, 0, 8'h00, "R6 frame last byte");
        send_async(8'h3C, 1); send_async(8'hFF, 1); send_async(8'h00, 1);
        idle(400);
        expect_e(1, 1, 0, 8'h81, "R6 single byte frame");
        send_async(8'h81, 1);
        idle(400);
        drained("R6 gap frames complete");

        // R5 transparent
        cfg(2'd1, 16'h0000);
        expect_e(0, 0, 0, 8'h12, "R5 plain byte");
        expect_e(0, 0, 0, 8'hA5, "R5 plain byte 2");
        send_async(8'h12, 1); send_async(8'hA5, 1);
        idle(400);
        drained("R5 transparent complete");

        // R3 framing error then a clean byte
        expect_e(0, 0, 1, 8'h5A, "R3 missing stop flagged");
        expect_e(0, 0, 0, 8'h33, "R3 recovery byte");
        send_async(8'h5A, 0);
        idle(40);
        send_async(8'h33, 1);
        idle(400);
        drained("R3 framing complete");

        // R2 short low pulse is rejected
        rx_async = 1'b0; idle(8); rx_async = 1'b1;
        idle(400);
        check(rd_valid == 1'b0, "R2 glitch produced no byte", int'(rd_valid), 0);
        expect_e(0, 0, 0, 8'h7E, "R2 byte after glitch");
        send_async(8'h7E, 1);
        idle(400);
        drained("R2 complete");

        // R7 sync-word policy in start-bit mode
        cfg(2'd1, 16'h0004);
        expect_e(1, 0, 0, 8'h42, "R7 first byte after sync");
        expect_e(0, 1, 0, 8'h43, "R7 last byte");
        send_async(8'h11, 1); send_async(8'hA5, 1);
        send_async(8'h42, 1); send_async(8'h43, 1);
        idle(400);
        drained("R7 frame complete");
        send_async(8'h42, 1);
        idle(400);
        drained("R7 byte without sync discarded");

        // R4 clocked mode, gap policy
        cfg(2'd1, 16'h0003);
        expect_e(1, 0, 0, 8'hC3, "R4 clocked first byte");
        expect_e(0, 1, 0, 8'h18, "R4 clocked last byte");
        sync_byte(8'hC3); sync_byte(8'h18);
        idle(400);
        drained("R4 clocked complete");

        // R8 clocked mode, bit-level sync hunt
        cfg(2'd1, 16'h0005);
        expect_e(1, 0, 0, 8'h6B, "R8 aligned first byte");
        expect_e(0, 1, 0, 8'h9D, "R8 aligned last byte");
        sync_bit(1'b0); sync_bit(1'b0); sync_bit(1'b0);
        sync_byte(8'hA5); sync_byte(8'h6B); sync_byte(8'h9D);
        idle(400);
        drained("R8 complete");

        // R10 overflow: queue depth 8, ten bytes offered
        cfg(2'd1, 16'h0000);
        drain_en = 1'b0;
        idle(4);
        for (int i = 0; i < 10; i++) begin
            if (i < 8) expect_e(0, 0, 0, 8'(8'h20 + i), "R10 kept entry");
            send_async(8'(8'h20 + i), 1);
        end
        idle(100);
        check(overflow == 1'b1, "R10 overflow set", int'(overflow), 1);
        check(rd_valid == 1'b1, "R9 entries held", int'(rd_valid), 1);
        drain_en = 1'b1;
        idle(60);
        drained("R10 only first entries kept");
        check(overflow == 1'b1, "R10 flag sticky after drain", int'(overflow), 1);
        cfg(2'd2, 16'h00A5);
        idle(2);
        check(overflow == 1'b0, "R10 cleared by write", int'(overflow), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule